// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit virtual addresses into 32-bit physical addresses using 16 kB pages. A request carries the virtual address, a user/supervisor flag, a write flag and a process-context identifier. The answer is a physical address or a fault code. A small fully associative translation cache sits in front of a walk engine. On a miss, the engine reads a 64-entry directory and then one table. It uses a simple memory-read port with one read in flight at a time.

A directory entry can mark its whole 64 MB region as using 256 kB pages. In that case the table has 256 entries and the region's physical base comes from the directory entry. Cached entries are tagged with the context identifier, so a context switch needs no flush. A flush input can clear the whole cache or only the entries of one context. The privilege and write checks are always made against a cached translation. A freshly walked translation is first written into the cache and then looked up again.

Top module: `pgx_mmu`

## Requirements
- R1: A small-page walk reads the directory word at {dir_base[31:8], va[31:26], 2'b00}, then the table word at {pde[31:14], va[25:14], 2'b00}. The result is {pte[31:14], va[13:0]}. Entry flags: bit 0 present, bit 1 writable, bit 2 user.
- R2: When directory entry bit 7 is set, the table word is read at {pde[31:14], 4'b0000, va[25:18], 2'b00}. The result is {pde[31:26], pte[25:18], va[17:0]}, and one cache entry then covers the whole 256 kB page.
- R3: A miss issues exactly two reads, directory then table. Each read is a one-cycle mem_req pulse, and the next read is not issued before mem_rvalid returns the previous word.
- R4: A request that hits the cache gets its response on the second clock edge after acceptance and issues no memory read.
- R5: Cache entries are tagged with the context identifier. The same address under another identifier walks again, and both translations then coexist.
- R6: A user request (req_user=1) to a page whose effective user permission (pde bit 2 AND pte bit 2) is 0 faults with code 3. Supervisor requests to that page succeed.
- R7: A write request to a page whose effective writable permission (pde bit 1 AND pte bit 1) is 0 faults with code 3.
- R8: A non-present directory entry faults with code 1 after one read. A non-present table entry faults with code 2 after two reads. No cache entry is written, so a repeat walks again. Every fault returns physical address 0; code 0 means no fault.
- R9: The cache holds 8 entries refilled in round-robin order. After 8 refills, a ninth evicts the oldest of them.
- R10: A flush with flush_all=1 invalidates every entry. A flush with flush_all=0 invalidates only entries whose identifier equals flush_ctx.
- R11: req_ready is low from the cycle after acceptance until the response. rsp_valid is a one-cycle pulse.
- R12: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-level request |
| req_write | input | 1 | 1 = write access |
| req_ctx | input | CTX_W | Process-context identifier |
| dir_base | input | 32 | Directory base, 256-byte aligned |
| flush_valid | input | 1 | Flush strobe |
| flush_all | input | 1 | 1 = clear all, 0 = clear one context |
| flush_ctx | input | CTX_W | Context to clear |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_kind | output | 2 | 0 none, 1 directory, 2 table, 3 privilege |
| rsp_paddr | output | 32 | Physical address, 0 on fault |

## Verification
On every cycle, the assertions check several properties. The cache never holds two matching entries for one lookup. A refill is visible to the next lookup, and a full flush empties the cache. A user hit on a supervisor entry always produces a privilege fault. Faults carry a zero address, memory strobes never come back to back, and acceptance always drops req_ready.

Address arithmetic, the two read addresses, big-page region composition, round-robin eviction order, per-context flushing and the absence of reads on hits can only be shown by the bench's scenarios. The bench compares against its own page-table model and counts the reads.

// File: rtl/pgx_pkg.sv
// Shared types and entry-format constants for the page translation unit.
// Assumes 32-bit virtual and physical addresses, 16 kB base pages.
package pgx_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int VPN_W  = 18;   // va[31:14]
    localparam int FRM_W  = 18;   // pa[31:14]
    localparam int BIT_P  = 0;    // present
    localparam int BIT_W  = 1;    // writable
    localparam int BIT_U  = 2;    // user accessible
    localparam int BIT_BG = 7;    // directory entry: 256 kB pages

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_TBL  = 2'd2,
        FLT_PRIV = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_DIR_RQ,
        ST_DIR_WT,
        ST_TBL_RQ,
        ST_TBL_WT
    } walk_st_e;

    typedef struct packed {
        logic             vld;
        logic             big;
        logic             usr;
        logic             wr;
        logic [VPN_W-1:0] vpn;
        logic [FRM_W-1:0] frame;
    } tlb_ent_t;
endpackage

// File: rtl/pgx_tlb.sv
// Fully associative translation cache with context tags.
// Lookup is combinational; fill and flush take effect at the clock edge.
// A fill in the same cycle as a flush survives the flush.
// Assumes the walker only fills on a miss, so at most one entry matches.
module pgx_tlb
    import pgx_pkg::*;
#(
    parameter int CTX_W = 12,
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [CTX_W-1:0]    lk_ctx,
    output logic                lk_hit,
    output logic [PA_W-1:0]     lk_paddr,
    output logic                lk_user,
    output logic                lk_wr,
    input  logic                fill_en,
    input  logic [CTX_W-1:0]    fill_ctx,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic                fill_big,
    input  logic                fill_user,
    input  logic                fill_wr,
    input  logic [FRM_W-1:0]    fill_frame,
    input  logic                flush_en,
    input  logic                flush_all,
    input  logic [CTX_W-1:0]    flush_ctx
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tlb_ent_t          ents [DEPTH];
    logic [CTX_W-1:0]  ctxs [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [PTR_W-1:0]  rr_ptr;
    logic [PTR_W-1:0]  rr_nxt;

    // Per-entry tag comparison; big entries compare only va[31:18].
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            logic tag_eq;
            assign tag_eq = ents[g].big ? (ents[g].vpn[VPN_W-1:4] == lk_vaddr[31:18])
                                        : (ents[g].vpn == lk_vaddr[31:14]);
            assign match[g] = ents[g].vld && tag_eq && (ctxs[g] == lk_ctx);
        end
    endgenerate

    // Merge the matching entry into the lookup result.
    always_comb begin
        lk_paddr = '0;
        lk_user  = 1'b0;
        lk_wr    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                lk_paddr = lk_paddr | (ents[i].big ? {ents[i].frame[FRM_W-1:4], lk_vaddr[17:0]}
                                                   : {ents[i].frame, lk_vaddr[13:0]});
                lk_user  = lk_user | ents[i].usr;
                lk_wr    = lk_wr | ents[i].wr;
            end
        end
    end
    assign lk_hit = |match;

    // Next round-robin slot, wrapping at DEPTH.
    assign rr_nxt = (rr_ptr == PTR_W'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;

    // Entry storage: flush first, then the refill write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
                ctxs[i] <= '0;
            end
            rr_ptr <= '0;
        end else begin
            if (flush_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (flush_all || (ctxs[i] == flush_ctx)) begin
                        ents[i].vld <= 1'b0;
                    end
                end
            end
            if (fill_en) begin
                ents[rr_ptr] <= '{vld: 1'b1, big: fill_big, usr: fill_user, wr: fill_wr,
                                  vpn: fill_vpn, frame: fill_frame};
                ctxs[rr_ptr] <= fill_ctx;
                rr_ptr       <= rr_nxt;
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && flush_all && !fill_en) |=> !lk_hit); // R10
endmodule

// File: rtl/pgx_perm.sv
// Privilege and write-permission check against a cached translation.
// Purely combinational; assumes the entry fields are valid only on a hit.
module pgx_perm (
    input  logic req_user,
    input  logic req_write,
    input  logic ent_user,
    input  logic ent_wr,
    output logic deny
);
    // Deny user access to supervisor pages and writes to read-only pages.
    always_comb begin
        deny = (req_user && !ent_user) || (req_write && !ent_wr);
    end
endmodule

// File: rtl/pgx_walker.sv
// Request control and two-level table walk.
// Holds one request at a time, checks the cache, walks on a miss and
// refills the cache, then re-enters lookup so the permission check is
// always made against a cached entry. Assumes mem_rvalid only answers a
// previously issued mem_req and dir_base is stable.
module pgx_walker
    import pgx_pkg::*;
#(
    parameter int CTX_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_user,
    input  logic                req_write,
    input  logic [CTX_W-1:0]    req_ctx,
    input  logic [PA_W-1:0]     dir_base,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [31:0]         mem_rdata,
    output logic [VA_W-1:0]     lk_vaddr,
    output logic [CTX_W-1:0]    lk_ctx,
    output logic                lk_active,
    output logic                q_user,
    output logic                q_write,
    input  logic                lk_hit,
    input  logic [PA_W-1:0]     lk_paddr,
    input  logic                deny,
    output logic                fill_en,
    output logic [CTX_W-1:0]    fill_ctx,
    output logic [VPN_W-1:0]    fill_vpn,
    output logic                fill_big,
    output logic                fill_user,
    output logic                fill_wr,
    output logic [FRM_W-1:0]    fill_frame,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [1:0]          rsp_kind,
    output logic [PA_W-1:0]     rsp_paddr
);
    walk_st_e          st;
    logic [VA_W-1:0]   q_va;
    logic [CTX_W-1:0]  q_ctx;
    logic [FRM_W-1:0]  pde_base;
    logic              pde_big;
    logic              pde_usr;
    logic              pde_wr;
    logic              unused_bits;

    assign unused_bits = ^{dir_base[7:0], mem_rdata[13:3]};

    assign req_ready = (st == ST_IDLE);
    assign lk_active = (st == ST_LOOK);
    assign lk_vaddr  = q_va;
    assign lk_ctx    = q_ctx;
    assign mem_req   = (st == ST_DIR_RQ) || (st == ST_TBL_RQ);

    // Read address for the directory or the table word.
    always_comb begin
        if (st == ST_DIR_RQ) begin
            mem_addr = {dir_base[31:8], q_va[31:26], 2'b00};
        end else if (pde_big) begin
            mem_addr = {pde_base, 4'b0000, q_va[25:18], 2'b00};
        end else begin
            mem_addr = {pde_base, q_va[25:14], 2'b00};
        end
    end

    // Refill contents built from the held directory entry and the table word.
    always_comb begin
        fill_en    = (st == ST_TBL_WT) && mem_rvalid && mem_rdata[BIT_P];
        fill_ctx   = q_ctx;
        fill_vpn   = q_va[31:14];
        fill_big   = pde_big;
        fill_user  = pde_usr && mem_rdata[BIT_U];
        fill_wr    = pde_wr && mem_rdata[BIT_W];
        fill_frame = pde_big ? {pde_base[FRM_W-1:12], mem_rdata[25:18], 4'b0000}
                             : mem_rdata[31:14];
    end

    // Walk state, held request and captured directory entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            q_va     <= '0;
            q_ctx    <= '0;
            q_user   <= 1'b0;
            q_write  <= 1'b0;
            pde_base <= '0;
            pde_big  <= 1'b0;
            pde_usr  <= 1'b0;
            pde_wr   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    q_va    <= req_vaddr;
                    q_ctx   <= req_ctx;
                    q_user  <= req_user;
                    q_write <= req_write;
                    st      <= ST_LOOK;
                end
                ST_LOOK:   st <= lk_hit ? ST_IDLE : ST_DIR_RQ;
                ST_DIR_RQ: st <= ST_DIR_WT;
                ST_DIR_WT: if (mem_rvalid) begin
                    pde_base <= mem_rdata[31:14];
                    pde_big  <= mem_rdata[BIT_BG];
                    pde_usr  <= mem_rdata[BIT_U];
                    pde_wr   <= mem_rdata[BIT_W];
                    st       <= mem_rdata[BIT_P] ? ST_TBL_RQ : ST_IDLE;
                end
                ST_TBL_RQ: st <= ST_TBL_WT;
                ST_TBL_WT: if (mem_rvalid) begin
                    st <= mem_rdata[BIT_P] ? ST_LOOK : ST_IDLE;
                end
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Response pulse: hit result, privilege fault or walk fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_kind  <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (st == ST_LOOK && lk_hit) begin
                rsp_valid <= 1'b1;
                rsp_fault <= deny;
                rsp_kind  <= deny ? FLT_PRIV : FLT_NONE;
                rsp_paddr <= deny ? '0 : lk_paddr;
            end else if (st == ST_DIR_WT && mem_rvalid && !mem_rdata[BIT_P]) begin
                rsp_valid <= 1'b1;
                rsp_fault <= 1'b1;
                rsp_kind  <= FLT_DIR;
                rsp_paddr <= '0;
            end else if (st == ST_TBL_WT && mem_rvalid && !mem_rdata[BIT_P]) begin
                rsp_valid <= 1'b1;
                rsp_fault <= 1'b1;
                rsp_kind  <= FLT_TBL;
                rsp_paddr <= '0;
            end
        end
    end

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11

    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_kind != FLT_NONE)); // R8
endmodule

// File: rtl/pgx_mmu.sv
// Top of the two-level page translation unit: walker, translation cache
// and permission check. Assumes a single requester and a memory port that
// answers each read strobe with exactly one mem_rvalid pulse.
module pgx_mmu
    import pgx_pkg::*;
#(
    parameter int CTX_W     = 12,
    parameter int TLB_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_user,
    input  logic              req_write,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [31:0]       dir_base,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [CTX_W-1:0]  flush_ctx,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_kind,
    output logic [31:0]       rsp_paddr
);
    logic [VA_W-1:0]   lk_vaddr;
    logic [CTX_W-1:0]  lk_ctx;
    logic              lk_active;
    logic              lk_hit;
    logic [PA_W-1:0]   lk_paddr;
    logic              lk_user;
    logic              lk_wr;
    logic              q_user;
    logic              q_write;
    logic              deny;
    logic              fill_en;
    logic [CTX_W-1:0]  fill_ctx;
    logic [VPN_W-1:0]  fill_vpn;
    logic              fill_big;
    logic              fill_user;
    logic              fill_wr;
    logic [FRM_W-1:0]  fill_frame;

    pgx_walker #(.CTX_W(CTX_W)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_write(req_write), .req_ctx(req_ctx),
        .dir_base(dir_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .lk_vaddr(lk_vaddr), .lk_ctx(lk_ctx), .lk_active(lk_active),
        .q_user(q_user), .q_write(q_write),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .deny(deny),
        .fill_en(fill_en), .fill_ctx(fill_ctx), .fill_vpn(fill_vpn), .fill_big(fill_big),
        .fill_user(fill_user), .fill_wr(fill_wr), .fill_frame(fill_frame),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr)
    );

    pgx_tlb #(.CTX_W(CTX_W), .DEPTH(TLB_DEPTH)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_ctx(lk_ctx),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_user(lk_user), .lk_wr(lk_wr),
        .fill_en(fill_en), .fill_ctx(fill_ctx), .fill_vpn(fill_vpn), .fill_big(fill_big),
        .fill_user(fill_user), .fill_wr(fill_wr), .fill_frame(fill_frame),
        .flush_en(flush_valid), .flush_all(flush_all), .flush_ctx(flush_ctx)
    );

    pgx_perm u_perm (
        .req_user(q_user), .req_write(q_write),
        .ent_user(lk_user), .ent_wr(lk_wr),
        .deny(deny)
    );

    AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (lk_active && lk_hit)); // R4

    AST_USER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_active && lk_hit && q_user && !lk_user) |=> (rsp_valid && rsp_kind == 2'd3)); // R6
endmodule

// File: tb/pgx_mmu_bench.sv
// Bench: directed corner cases plus seeded random traffic against a
// page-table model computed by bench functions.
module pgx_mmu_bench;
    localparam int CW = 12;
    localparam logic [31:0] DIR_BASE = 32'h0001_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_vaddr = '0;
    logic          req_user = 1'b0;
    logic          req_write = 1'b0;
    logic [CW-1:0] req_ctx = '0;
    logic          flush_valid = 1'b0;
    logic          flush_all = 1'b0;
    logic [CW-1:0] flush_ctx = '0;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [1:0]    rsp_kind;
    logic [31:0]   rsp_paddr;

    int nchk = 0;
    int nfail = 0;
    int nreads = 0;
    logic [31:0] rd_log [4];
    bit finished = 0;

    always #4 clk = ~clk;

    pgx_mmu #(.CTX_W(CW), .TLB_DEPTH(8)) u_pgx_mmu (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_write(req_write), .req_ctx(req_ctx),
        .dir_base(DIR_BASE),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_ctx(flush_ctx),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr)
    );

    // Page-table memory image, computed from the address.
    function automatic logic [31:0] pt_read(input logic [31:0] a);
        logic [11:0] ix;
        ix = a[13:2];
        if (a[31:8] == DIR_BASE[31:8]) begin
            case (a[7:2])
                6'd0:    return 32'h0010_0007;
                6'd1:    return 32'h2800_0087;
                6'd3:    return 32'h0030_0003;
                default: return 32'h0;
            endcase
        end
        if (a[31:14] == 18'h00040 && ix < 12'd16)
            return {18'h00100 + 18'(ix) * 18'd3, 11'd0,
                    (ix != 12'd6), (ix != 12'd7), (ix != 12'd5)};
        if (a[31:14] == 18'h000C0 && ix < 12'd4)
            return {18'h00200 + 18'(ix), 14'h7};
        if (a[31:10] == 22'h0A_0000 && a[9:2] < 8'd8)
            return {6'h3F, 8'h40 + a[9:2], 15'd0, 2'b11, (a[9:2] != 8'd3)};
        return 32'h0;
    endfunction

    // Expected translation per R1, R2, R6, R7, R8.
    task automatic ref_xlate(input logic [31:0] va, input logic usr, input logic wr,
                             output logic [31:0] pa, output logic [1:0] kind);
        logic [31:0] pde, pte;
        logic big;
        pde = pt_read({DIR_BASE[31:8], va[31:26], 2'b00});
        if (!pde[0]) begin pa = 0; kind = 2'd1; return; end
        big = pde[7];
        pte = pt_read(big ? {pde[31:14], 4'b0, va[25:18], 2'b00} : {pde[31:14], va[25:14], 2'b00});
        if (!pte[0]) begin pa = 0; kind = 2'd2; return; end
        if ((usr && !(pde[2] && pte[2])) || (wr && !(pde[1] && pte[1]))) begin
            pa = 0; kind = 2'd3; return;
        end
        pa = big ? {pde[31:26], pte[25:18], va[17:0]} : {pte[31:14], va[13:0]};
        kind = 2'd0;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Memory responder: 1..3 cycle latency, logs read addresses.
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                logic [31:0] a;
                int lat;
                a = mem_addr;
                if (nreads < 4) rd_log[nreads] = a;
                nreads++;
                lat = $urandom_range(1, 3);
                repeat (lat) @(negedge clk);
                mem_rdata  = pt_read(a);
                mem_rvalid = 1'b1;
            end
        end
    end

    // One translation; returns result, latency in negedges after acceptance.
    task automatic xlate(input logic [31:0] va, input logic usr, input logic wr, input logic [CW-1:0] ctx,
                         output logic [31:0] pa, output logic [1:0] kind, output logic flt, output int lat);
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_user = usr; req_write = wr; req_ctx = ctx;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        chk(!req_ready, "R11 ready low after accept", 32'(req_ready), 32'd0);
        while (!rsp_valid) begin @(negedge clk); lat++; end
        pa = rsp_paddr; kind = rsp_kind; flt = rsp_fault;
        @(negedge clk);
        chk(!rsp_valid, "R11 single-cycle response", 32'(rsp_valid), 32'd0);
    endtask

    // Translate and compare against the model; exp_reads < 0 skips the read count.
    task automatic run(input logic [31:0] va, input logic usr, input logic wr, input logic [CW-1:0] ctx,
                       input int exp_reads, input string req);
        logic [31:0] pa, epa;
        logic [1:0] kind, ekind;
        logic flt;
        int lat;
        xlate(va, usr, wr, ctx, pa, kind, flt, lat);
        ref_xlate(va, usr, wr, epa, ekind);
        chk(pa == epa, {req, " paddr"}, pa, epa);
        chk(kind == ekind && flt == (ekind != 2'd0), {req, " fault code"}, {29'd0, flt, kind}, {29'd0, ekind != 2'd0, ekind});
        if (exp_reads >= 0) chk(nreads == exp_reads, {req, " read count"}, 32'(nreads), 32'(exp_reads));
        if (exp_reads == 0 && ekind != 2'd1 && ekind != 2'd2)
            chk(lat == 2, "R4 hit latency", 32'(lat), 32'd2);
    endtask

    task automatic flush(input logic all, input logic [CW-1:0] ctx);
        @(negedge clk);
        flush_valid = 1'b1; flush_all = all; flush_ctx = ctx;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    function automatic logic [31:0] va_small(input int ix, input logic [13:0] off);
        return {6'd0, 12'(ix), off};
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 req_ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 32'd0);

        // R1 / R3 small-page walk and its two addresses
        run(va_small(1, 14'h0123), 1'b1, 1'b0, 12'd1, 2, "R3 walk");
        chk(rd_log[0] == DIR_BASE, "R1 directory address", rd_log[0], DIR_BASE);
        chk(rd_log[1] == 32'h0010_0004, "R1 table address", rd_log[1], 32'h0010_0004);
        // R4 repeat hits
        run(va_small(1, 14'h3FFF), 1'b1, 1'b0, 12'd1, 0, "R4 hit");

        // R2 big page
        run({6'd1, 8'd2, 18'h2ABCD}, 1'b1, 1'b0, 12'd1, 2, "R2 big walk");
        chk(rd_log[0] == DIR_BASE + 32'd4, "R2 directory address", rd_log[0], DIR_BASE + 32'd4);
        chk(rd_log[1] == 32'h2800_0008, "R2 table address", rd_log[1], 32'h2800_0008);
        run({6'd1, 8'd2, 18'h00010}, 1'b0, 1'b1, 12'd1, 0, "R2 big page cached");

        // R5 context tags
        run(va_small(1, 14'h0040), 1'b1, 1'b0, 12'd2, 2, "R5 other context walks");
        run(va_small(1, 14'h0040), 1'b1, 1'b0, 12'd1, 0, "R5 first context kept");
        run(va_small(1, 14'h0044), 1'b1, 1'b0, 12'd2, 0, "R5 second context kept");

        // R6 privilege
        run({6'd3, 12'd0, 14'h0100}, 1'b1, 1'b0, 12'd1, 2, "R6 user to supervisor region");
        run({6'd3, 12'd0, 14'h0100}, 1'b0, 1'b0, 12'd1, 0, "R6 supervisor allowed");
        run(va_small(6, 14'h0008), 1'b1, 1'b0, 12'd1, 2, "R6 user to supervisor page");
        run(va_small(6, 14'h0008), 1'b0, 1'b0, 12'd1, 0, "R6 supervisor page ok");

        // R7 write permission
        run(va_small(7, 14'h0010), 1'b0, 1'b1, 12'd1, 2, "R7 write to read-only");
        run(va_small(7, 14'h0010), 1'b1, 1'b0, 12'd1, 0, "R7 read allowed");

        // R8 non-present entries, no refill
        run({6'd2, 26'h0ABCDEF}, 1'b0, 1'b0, 12'd1, 1, "R8 directory fault");
        run({6'd2, 26'h0ABCDEF}, 1'b0, 1'b0, 12'd1, 1, "R8 directory fault repeat");
        run(va_small(5, 14'h0001), 1'b0, 1'b0, 12'd1, 2, "R8 table fault");
        run(va_small(5, 14'h0001), 1'b0, 1'b0, 12'd1, 2, "R8 table fault repeat");
        run({6'd1, 8'd3, 18'h00001}, 1'b0, 1'b0, 12'd1, 2, "R8 big table fault");

        // R9 round-robin eviction
        flush(1'b1, 12'd0);
        foreach (rd_log[k]) rd_log[k] = '0;
        for (int i = 0; i < 12; i++) begin
            if (i == 5 || i == 6 || i == 7) continue;
            run(va_small(i, 14'h0020), 1'b0, 1'b0, 12'd1, 2, "R9 fill");
        end
        run(va_small(10, 14'h0024), 1'b0, 1'b0, 12'd1, 0, "R9 recent entry kept");
        run(va_small(0, 14'h0024), 1'b0, 1'b0, 12'd1, 2, "R9 oldest evicted");

        // R10 flush by context and flush all
        flush(1'b1, 12'd0);
        run(va_small(12, 14'h0100), 1'b0, 1'b0, 12'd1, 2, "R10 fill ctx1");
        run(va_small(12, 14'h0100), 1'b0, 1'b0, 12'd2, 2, "R10 fill ctx2");
        flush(1'b0, 12'd1);
        run(va_small(12, 14'h0104), 1'b0, 1'b0, 12'd2, 0, "R10 other context survives");
        run(va_small(12, 14'h0104), 1'b0, 1'b0, 12'd1, 2, "R10 flushed context walks");
        flush(1'b1, 12'd0);
        run(va_small(12, 14'h0108), 1'b0, 1'b0, 12'd2, 2, "R10 flush all");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [31:0] va;
            sel = $urandom_range(0, 3);
            case (sel)
                0: va = {6'd0, 12'($urandom_range(0, 19)), 14'($urandom)};
                1: va = {6'd1, 8'($urandom_range(0, 7)), 18'($urandom)};
                2: va = {6'd2, 26'($urandom)};
                default: va = {6'd3, 12'($urandom_range(0, 3)), 14'($urandom)};
            endcase
            if ($urandom_range(0, 19) == 0) flush($urandom_range(0, 1) == 1, 12'($urandom_range(1, 3)));
            case (sel)
                0: run(va, 1'($urandom), 1'($urandom), 12'($urandom_range(1, 3)), -1, "R1 random");
                1: run(va, 1'($urandom), 1'($urandom), 12'($urandom_range(1, 3)), -1, "R2 random");
                2: run(va, 1'($urandom), 1'($urandom), 12'($urandom_range(1, 3)), 1, "R8 random");
                default: run(va, 1'($urandom), 1'($urandom), 12'($urandom_range(1, 3)), -1, "R6 random");
            endcase
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule